// File: doc/BRIEF.md
# Software Flow-Control Character Tracker

This block watches the byte streams leaving and entering a serial port and recognises software flow-control characters in them. Four host-programmed 8-bit characters define them: two "resume" (Xon) characters and two "pause" (Xoff) characters. A mode input selects how a control event is formed. In single mode, the first Xon or Xoff character alone is an event. In pair mode, an event needs the first character followed by the second one.

For each direction, the block keeps a "last event" indication in a 4-bit status field of an 8-bit status byte. Each bit clears when the host reads the byte. The whole field is held at zero while flow control is disabled. Every recognised event also raises a one-cycle detect pulse, which the surrounding port logic can use. Pausing the transmitter and inserting characters are left to other logic.

Top module: `xon_xoff_tracker`

## Requirements
- R1: A write with `cfgWrEn` high loads `cfgData` into the character chosen by `cfgSel`: 0 = Xon first, 1 = Xon second, 2 = Xoff first, 3 = Xoff second. Writes are accepted whether or not flow control is enabled.
- R2: In single mode (`pairMode` low) with flow control enabled, a valid transmit byte equal to the Xon first character sets status bit 3. A valid transmit byte equal to the Xoff first character sets status bit 2. Either result is visible after the clock edge that samples the byte.
- R3: The receive direction behaves the same way. An Xon event sets status bit 1 and an Xoff event sets status bit 0.
- R4: In pair mode, an event is recorded only when a valid byte equal to the second character follows a valid byte equal to the matching first character. Cycles with no valid byte between the two are allowed. A second character seen on its own does nothing.
- R5: In pair mode, a valid byte that does not complete the pending pair aborts it. That byte may itself start a new pair.
- R6: Within one direction, recording an Xon clears that direction's Xoff bit, and recording an Xoff clears its Xon bit. The other direction's bits are unaffected.
- R7: A cycle with `statusRd` high clears all four status bits at that clock edge.
- R8: If an event and a read occur in the same cycle, the event's bit stays set after the edge. The other bits clear.
- R9: While `flowEn` is low, the status byte is zero, no event is recognised, and any half-received pair is forgotten.
- R10: Status bits 7 to 4 always read as zero.
- R11: If a byte equals both an Xon and an Xoff first character, it is recorded as an Xoff.
- R12: Each event raises exactly its own detect pulse for one cycle, in the same cycle its status bit first shows.
- R13: Bytes that match no active control character, and cycles with the valid strobe low, leave the status unchanged and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flowEn | input | 1 | Software flow control enable |
| pairMode | input | 1 | 1 = two-character events, 0 = single-character events |
| cfgWrEn | input | 1 | Character register write strobe |
| cfgSel | input | 2 | Character register select |
| cfgData | input | 8 | Character value to write |
| txValid | input | 1 | Transmit byte strobe |
| txData | input | 8 | Transmit byte |
| rxValid | input | 1 | Receive byte strobe |
| rxData | input | 8 | Receive byte |
| statusRd | input | 1 | Status read strobe (clear on read) |
| statusOut | output | 8 | Status byte |
| txOnPulse | output | 1 | Transmit Xon event pulse |
| txOffPulse | output | 1 | Transmit Xoff event pulse |
| rxOnPulse | output | 1 | Receive Xon event pulse |
| rxOffPulse | output | 1 | Receive Xoff event pulse |

## Verification
Every result is due one edge after its stimulus. A byte strobe, read, enable change or character write that is sampled at one rising edge shows in both the status byte and the pulses right after that same edge. The bench drives each stimulus on a falling edge and queues the expected status and pulse values for it. The monitor then compares them shortly after the next rising edge, so every comparison falls on the cycle in which the result first becomes visible.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  typedef struct packed {
    logic on1;
    logic on2;
    logic off1;
    logic off2;
  } xfcMatch_t;

  typedef struct packed {
    logic txOn;
    logic txOff;
    logic rxOn;
    logic rxOff;
    logic rdClr;
    logic flushAll;
  } xfcStrobes_t;

  typedef enum logic [1:0] {
    HUNT     = 2'd0,
    HALF_ON  = 2'd1,
    HALF_OFF = 2'd2
  } pairState_t;

  localparam int NUM_CHARS = 4;
  localparam int SEL_ON1   = 0;
  localparam int SEL_ON2   = 1;
  localparam int SEL_OFF1  = 2;
  localparam int SEL_OFF2  = 3;

endpackage

// File: rtl/xfc_pair_seq.sv
module xfc_pair_seq
  import xfc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      pairMode,
  input  logic      valid,
  input  xfcMatch_t match,
  output logic      evOn,
  output logic      evOff
);

  pairState_t state, stateNxt;
  logic onRaw, offRaw;

  always_comb begin
    onRaw    = 1'b0;
    offRaw   = 1'b0;
    stateNxt = state;
    if (!pairMode) begin
      stateNxt = HUNT;
      if (valid) begin
        offRaw = match.off1;
        onRaw  = match.on1 && !match.off1;
      end
    end else if (valid) begin
      if (state == HALF_ON && match.on2) begin
        onRaw    = 1'b1;
        stateNxt = HUNT;
      end else if (state == HALF_OFF && match.off2) begin
        offRaw   = 1'b1;
        stateNxt = HUNT;
      end else if (match.off1) begin
        stateNxt = HALF_OFF;
      end else if (match.on1) begin
        stateNxt = HALF_ON;
      end else begin
        stateNxt = HUNT;
      end
    end
  end

  assign evOn  = enable && onRaw;
  assign evOff = enable && offRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   state <= HUNT;
    else if (!enable || !pairMode) state <= HUNT;
    else                         state <= stateNxt;
  end

  // R6: a single byte yields at most one event kind
  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(evOn && evOff));

  // R9: disabling forgets any half-received pair
  a_r9_forget_half: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> state == HUNT);

  // R4: a pair-mode event always completes a pending half
  a_r4_pair_from_half: assert property (@(posedge clk) disable iff (!rstN)
    (pairMode && (evOn || evOff)) |-> state != HUNT);

endmodule

// File: rtl/xfc_control.sv
module xfc_control
  import xfc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        flowEn,
  input  logic        pairMode,
  input  logic        txValid,
  input  logic        rxValid,
  input  logic        statusRd,
  input  xfcMatch_t   txMatch,
  input  xfcMatch_t   rxMatch,
  output xfcStrobes_t strobes
);

  localparam int NUM_DIRS = 2;

  logic      validArr [NUM_DIRS];
  xfcMatch_t matchArr [NUM_DIRS];
  logic      evOnArr  [NUM_DIRS];
  logic      evOffArr [NUM_DIRS];

  assign validArr[0] = txValid;
  assign validArr[1] = rxValid;
  assign matchArr[0] = txMatch;
  assign matchArr[1] = rxMatch;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xfc_pair_seq u_seq (
      .clk      (clk),
      .rstN     (rstN),
      .enable   (flowEn),
      .pairMode (pairMode),
      .valid    (validArr[d]),
      .match    (matchArr[d]),
      .evOn     (evOnArr[d]),
      .evOff    (evOffArr[d])
    );
  end

  always_comb begin
    strobes.txOn     = evOnArr[0];
    strobes.txOff    = evOffArr[0];
    strobes.rxOn     = evOnArr[1];
    strobes.rxOff    = evOffArr[1];
    strobes.rdClr    = statusRd;
    strobes.flushAll = !flowEn;
  end

  // R9: no event strobe while flow control is disabled
  a_r9_no_event_off: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |-> !(strobes.txOn || strobes.txOff || strobes.rxOn || strobes.rxOff));

  // R13: no event without a valid byte in that direction
  a_r13_tx_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txOn || strobes.txOff) |-> txValid);
  a_r13_rx_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxOn || strobes.rxOff) |-> rxValid);

endmodule

// File: rtl/xfc_datapath.sv
module xfc_datapath
  import xfc_pkg::*;
#(
  parameter int              CHAR_W     = 8,
  parameter int              STAT_W     = 8,
  parameter logic [CHAR_W-1:0] RST_ON_CHAR  = 8'h11,
  parameter logic [CHAR_W-1:0] RST_OFF_CHAR = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CHAR_W-1:0] cfgData,
  input  logic [CHAR_W-1:0] txData,
  input  logic [CHAR_W-1:0] rxData,
  input  xfcStrobes_t       strobes,
  output xfcMatch_t         txMatch,
  output xfcMatch_t         rxMatch,
  output logic [STAT_W-1:0] statusOut,
  output logic [3:0]        pulses
);

  localparam int EVT_BITS = 4;
  localparam int PAD_W    = STAT_W - EVT_BITS;

  logic [CHAR_W-1:0] ctrlChar [NUM_CHARS];
  logic [EVT_BITS-1:0] stat;
  logic [EVT_BITS-1:0] statNxt;

  // character registers
  for (genvar c = 0; c < NUM_CHARS; c++) begin : g_char
    localparam logic [CHAR_W-1:0] RST_VAL =
      (c == SEL_ON1 || c == SEL_ON2) ? RST_ON_CHAR : RST_OFF_CHAR;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                ctrlChar[c] <= RST_VAL;
      else if (cfgWrEn && (int'(cfgSel) == c))  ctrlChar[c] <= cfgData;
    end
  end

  // comparators, one set per direction
  function automatic xfcMatch_t cmpByte(input logic [CHAR_W-1:0] b,
                                        input logic [CHAR_W-1:0] on1,
                                        input logic [CHAR_W-1:0] on2,
                                        input logic [CHAR_W-1:0] off1,
                                        input logic [CHAR_W-1:0] off2);
    xfcMatch_t m;
    m.on1  = (b == on1);
    m.on2  = (b == on2);
    m.off1 = (b == off1);
    m.off2 = (b == off2);
    return m;
  endfunction

  assign txMatch = cmpByte(txData, ctrlChar[SEL_ON1], ctrlChar[SEL_ON2],
                           ctrlChar[SEL_OFF1], ctrlChar[SEL_OFF2]);
  assign rxMatch = cmpByte(rxData, ctrlChar[SEL_ON1], ctrlChar[SEL_ON2],
                           ctrlChar[SEL_OFF1], ctrlChar[SEL_OFF2]);

  // per-direction last-event update: event beats read, read beats hold
  function automatic logic [1:0] dirUpdate(input logic [1:0] cur,
                                           input logic evOn, input logic evOff,
                                           input logic rd);
    if (evOff)     return 2'b01;
    else if (evOn) return 2'b10;
    else if (rd)   return 2'b00;
    else           return cur;
  endfunction

  always_comb begin
    statNxt[3:2] = dirUpdate(stat[3:2], strobes.txOn, strobes.txOff, strobes.rdClr);
    statNxt[1:0] = dirUpdate(stat[1:0], strobes.rxOn, strobes.rxOff, strobes.rdClr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat   <= '0;
      pulses <= '0;
    end else if (strobes.flushAll) begin
      stat   <= '0;
      pulses <= '0;
    end else begin
      stat   <= statNxt;
      pulses <= {strobes.txOn, strobes.txOff, strobes.rxOn, strobes.rxOff};
    end
  end

  assign statusOut = {{PAD_W{1'b0}}, stat};

  // R6: never both kinds recorded in one direction
  a_r6_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stat[3] && stat[2]));
  a_r6_rx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stat[1] && stat[0]));

  // R9: disable empties the status field
  a_r9_flush: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flushAll |=> stat == '0);

  // R7: a read with no event clears every bit
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdClr && !(strobes.txOn || strobes.txOff || strobes.rxOn || strobes.rxOff))
      |=> stat == '0);

  // R8: an event survives a simultaneous read
  a_r8_rx_on_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxOn && !strobes.flushAll) |=> stat[1]);
  a_r8_tx_off_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txOff && !strobes.flushAll) |=> stat[2]);

  // R12: a pulse accompanies its set bit, one kind per direction
  a_r12_pulse_bit: assert property (@(posedge clk) disable iff (!rstN)
    (pulses & ~stat) == '0);
  a_r12_pulse_kind: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulses[3:2]) && $onehot0(pulses[1:0]));

  // R13: status holds when nothing happens
  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.txOn || strobes.txOff || strobes.rxOn || strobes.rxOff ||
      strobes.rdClr || strobes.flushAll) |=> $stable(stat));

endmodule

// File: rtl/xon_xoff_tracker.sv
module xon_xoff_tracker
  import xfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowEn,
  input  logic              pairMode,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [CHAR_W-1:0] cfgData,
  input  logic              txValid,
  input  logic [CHAR_W-1:0] txData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              statusRd,
  output logic [STAT_W-1:0] statusOut,
  output logic              txOnPulse,
  output logic              txOffPulse,
  output logic              rxOnPulse,
  output logic              rxOffPulse
);

  xfcStrobes_t strobes;
  xfcMatch_t   txMatch, rxMatch;
  logic [3:0]  pulses;

  xfc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flowEn   (flowEn),
    .pairMode (pairMode),
    .txValid  (txValid),
    .rxValid  (rxValid),
    .statusRd (statusRd),
    .txMatch  (txMatch),
    .rxMatch  (rxMatch),
    .strobes  (strobes)
  );

  xfc_datapath #(
    .CHAR_W (CHAR_W),
    .STAT_W (STAT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgData   (cfgData),
    .txData    (txData),
    .rxData    (rxData),
    .strobes   (strobes),
    .txMatch   (txMatch),
    .rxMatch   (rxMatch),
    .statusOut (statusOut),
    .pulses    (pulses)
  );

  assign {txOnPulse, txOffPulse, rxOnPulse, rxOffPulse} = pulses;

endmodule

// File: tb/xon_xoff_tracker_test.sv
module xon_xoff_tracker_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] st;
    logic [3:0] pu;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flowEn = 1'b0, pairMode = 1'b0, cfgWrEn = 1'b0;
  logic [1:0] cfgSel = '0;
  logic [7:0] cfgData = '0, txData = '0, rxData = '0;
  logic       txValid = 1'b0, rxValid = 1'b0, statusRd = 1'b0;
  logic [7:0] statusOut;
  logic       txOnPulse, txOffPulse, rxOnPulse, rxOffPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xon_xoff_tracker uut (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .pairMode(pairMode),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .txValid(txValid), .txData(txData), .rxValid(rxValid), .rxData(rxData),
    .statusRd(statusRd), .statusOut(statusOut),
    .txOnPulse(txOnPulse), .txOffPulse(txOffPulse),
    .rxOnPulse(rxOnPulse), .rxOffPulse(rxOffPulse)
  );

  // monitor: compare one queued expectation per rising edge
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      expItem_t e;
      logic [3:0] pu;
      e  = q.pop_front();
      pu = {txOnPulse, txOffPulse, rxOnPulse, rxOffPulse};
      checks++;
      if (statusOut !== e.st || pu !== e.pu) begin
        fails++;
        $display("FAIL %s: status=%02h pulses=%04b expected status=%02h pulses=%04b",
                 e.tag, statusOut, pu, e.st, e.pu);
      end
    end
  end

  task automatic step(input logic fe, input logic pm,
                      input logic tv, input logic [7:0] td,
                      input logic rv, input logic [7:0] rd,
                      input logic rdS,
                      input logic [7:0] es, input logic [3:0] ep, input string tag);
    expItem_t e;
    @(negedge clk);
    flowEn = fe; pairMode = pm; cfgWrEn = 1'b0;
    txValid = tv; txData = td; rxValid = rv; rxData = rd; statusRd = rdS;
    e.st = es; e.pu = ep; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic writeChar(input logic fe, input logic pm, input logic [1:0] sel,
                           input logic [7:0] val,
                           input logic [7:0] es, input string tag);
    expItem_t e;
    @(negedge clk);
    flowEn = fe; pairMode = pm; cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    txValid = 1'b0; rxValid = 1'b0; statusRd = 1'b0;
    e.st = es; e.pu = 4'b0000; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (statusOut !== 8'h00) begin
      fails++;
      $display("FAIL R10 reset: status=%02h expected=00", statusOut);
    end

    // R1: program Xon1=11 Xon2=21 Xoff1=13 Xoff2=23
    writeChar(1, 0, 2'd0, 8'h11, 8'h00, "R1 write xon1");
    writeChar(1, 0, 2'd1, 8'h21, 8'h00, "R1 write xon2");
    writeChar(1, 0, 2'd2, 8'h13, 8'h00, "R1 write xoff1");
    writeChar(1, 0, 2'd3, 8'h23, 8'h00, "R1 write xoff2");

    // single mode, R2 R3 R6 R12
    step(1, 0, 1, 8'h11, 0, 8'h00, 0, 8'h08, 4'b1000, "R2 tx xon");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 8'h08, 4'b0000, "R12 pulse one cycle");
    step(1, 0, 1, 8'h13, 0, 8'h00, 0, 8'h04, 4'b0100, "R6 tx xoff clears xon");
    step(1, 0, 0, 8'h00, 1, 8'h11, 0, 8'h06, 4'b0010, "R3 rx xon");
    step(1, 0, 0, 8'h00, 1, 8'h13, 0, 8'h05, 4'b0001, "R3 rx xoff, R6 tx kept");
    step(1, 0, 1, 8'h55, 1, 8'h21, 0, 8'h05, 4'b0000, "R13 non-control bytes");
    step(1, 0, 0, 8'h11, 0, 8'h13, 0, 8'h05, 4'b0000, "R13 valid low");
    step(1, 0, 0, 8'h00, 0, 8'h00, 1, 8'h00, 4'b0000, "R7 read clears");
    step(1, 0, 0, 8'h00, 1, 8'h13, 0, 8'h01, 4'b0001, "R3 rx xoff again");
    step(1, 0, 1, 8'h13, 0, 8'h00, 1, 8'h04, 4'b0100, "R8 event wins over read");

    // R11: Xon1 equal to Xoff1
    writeChar(1, 0, 2'd0, 8'h13, 8'h04, "R1 write xon1=13");
    step(1, 0, 0, 8'h00, 1, 8'h13, 0, 8'h05, 4'b0001, "R11 xoff priority");
    writeChar(0, 0, 2'd0, 8'h11, 8'h00, "R9 disable clears, R1 write while off");

    // R9: disabled
    step(0, 0, 1, 8'h11, 1, 8'h13, 0, 8'h00, 4'b0000, "R9 no detect while off");
    step(1, 0, 1, 8'h11, 0, 8'h00, 0, 8'h08, 4'b1000, "R1 restored xon1 used");

    // pair mode R4
    step(1, 1, 0, 8'h00, 0, 8'h00, 1, 8'h00, 4'b0000, "R7 read");
    step(1, 1, 1, 8'h11, 0, 8'h00, 0, 8'h00, 4'b0000, "R4 first char only");
    step(1, 1, 0, 8'h00, 0, 8'h00, 0, 8'h00, 4'b0000, "R4 gap");
    step(1, 1, 1, 8'h21, 0, 8'h00, 0, 8'h08, 4'b1000, "R4 pair xon");
    step(1, 1, 1, 8'h23, 0, 8'h00, 0, 8'h08, 4'b0000, "R4 lone second char");

    // R5 abort
    step(1, 1, 0, 8'h00, 1, 8'h13, 0, 8'h08, 4'b0000, "R5 rx xoff1");
    step(1, 1, 0, 8'h00, 1, 8'h55, 0, 8'h08, 4'b0000, "R5 abort byte");
    step(1, 1, 0, 8'h00, 1, 8'h23, 0, 8'h08, 4'b0000, "R5 aborted pair");
    step(1, 1, 0, 8'h00, 1, 8'h13, 0, 8'h08, 4'b0000, "R5 rx xoff1 again");
    step(1, 1, 0, 8'h00, 1, 8'h23, 0, 8'h09, 4'b0001, "R5 rx pair xoff");
    step(1, 1, 1, 8'h11, 0, 8'h00, 0, 8'h09, 4'b0000, "R5 tx xon1");
    step(1, 1, 1, 8'h13, 0, 8'h00, 0, 8'h09, 4'b0000, "R5 restart with xoff1");
    step(1, 1, 1, 8'h23, 0, 8'h00, 0, 8'h05, 4'b0100, "R5 restarted pair xoff");

    // R9 forget half pair
    step(1, 1, 0, 8'h00, 1, 8'h11, 0, 8'h05, 4'b0000, "R9 rx xon1");
    step(0, 1, 0, 8'h00, 0, 8'h00, 0, 8'h00, 4'b0000, "R9 disable mid pair");
    step(1, 1, 0, 8'h00, 1, 8'h21, 0, 8'h00, 4'b0000, "R9 half pair forgotten");
    step(1, 1, 0, 8'h00, 0, 8'h00, 0, 8'h00, 4'b0000, "R10 idle");

    @(negedge clk);
    txValid = 1'b0; rxValid = 1'b0; statusRd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule